// File: doc/BRIEF.md
# Stack Window Guard

The guard sits next to the load/store address adder of a 32-bit processor. It keeps a lower and an upper bound for the stack. For every load or store whose address uses the stack-pointer register (register index 1) as base or index, it compares the computed effective address against those bounds. If the address falls outside the window, the guard raises a hardware exception pulse in the same cycle. It then records the faulting address and a cause code in syndrome registers, which the exception logic can read.

Software programs the bounds through special-register moves. The lower bound is at special-register number 0x800 and the upper bound at 0x802. Both are readable through a combinational read port. After reset the window covers the whole address space, so the check is disabled until software narrows it.

Top module: `stack_window_guard`

## Requirements
- R1: After reset the lower bound reads 0x00000000 and the upper bound reads 0xFFFFFFFF. The captured address and cause are 0, and no access can fault.
- R2: A write with spr_wr_i=1 to number 0x800 loads the lower bound, and one to 0x802 loads the upper bound, at the clock edge. spr_rdata_o returns the bound selected by spr_raddr_i in the same cycle.
- R3: A write to any other special-register number changes neither bound. A read of any other number returns 0.
- R4: An access faults when its address, taken as unsigned, is below the lower bound or above the upper bound. An address equal to either bound does not fault.
- R5: With register+register addressing (ls_reg_reg_i=1), the access is checked when ls_ra_i=1 or ls_rb_i=1.
- R6: With register+immediate addressing (ls_reg_reg_i=0), the access is checked only when ls_ra_i=1. The value of ls_rb_i has no effect.
- R7: fault_o is combinational. It is high only in a cycle where ls_valid_i=1 and a checked access is out of the window. It is never high otherwise.
- R8: At the edge that ends a fault cycle, ear_o loads the faulting address and cause_o loads 7. Both hold their values until the next fault.
- R9: When a bound write and a checked access fall in the same cycle, the access is compared against the bound value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spr_wr_i | input | 1 | Special-register write strobe |
| spr_waddr_i | input | 14 | Special-register number being written |
| spr_wdata_i | input | 32 | Write data from the general register |
| spr_raddr_i | input | 14 | Special-register number being read |
| spr_rdata_o | output | 32 | Read data for the selected bound, 0 if none |
| ls_valid_i | input | 1 | Load/store address valid strobe |
| ls_reg_reg_i | input | 1 | 1 for register+register, 0 for register+immediate |
| ls_ra_i | input | 5 | Base register index |
| ls_rb_i | input | 5 | Index register index |
| ls_addr_i | input | 32 | Computed effective address |
| fault_o | output | 1 | Stack window violation pulse |
| ear_o | output | 32 | Captured faulting address |
| cause_o | output | 5 | Captured exception cause |

## Verification
The assertions check on every cycle that a fault needs a valid strobe and a stack-pointer operand, and that it needs an address outside the current bounds. They also check that the syndrome registers load the right address and cause after each fault and hold in between. A further check is that the bounds stay unchanged unless one of the two numbers is written. Some behaviour needs the bench's scenarios: faults that should have fired but did not, the inclusive edges of the window, the reset-disabled state, and the old-bound compare on a same-cycle write. The bench sweeps register indices, both addressing formats and addresses around both bounds against a model.

// File: rtl/sw_guard_pkg.sv
package sw_guard_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned IDX_W      = 5;
  localparam int unsigned SPR_W      = 14;
  localparam int unsigned CAUSE_W    = 5;
  localparam int unsigned SP_IDX     = 1;
  localparam logic [SPR_W-1:0] LO_NUM = 14'h800;
  localparam logic [SPR_W-1:0] HI_NUM = 14'h802;
  localparam logic [CAUSE_W-1:0] CAUSE_STACK = 5'd7;
endpackage

// File: rtl/sw_limit_regs.sv
module sw_limit_regs #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SPR_W  = 14,
  parameter logic [SPR_W-1:0] LO_NUM = '0,
  parameter logic [SPR_W-1:0] HI_NUM = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SPR_W-1:0]  waddr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [SPR_W-1:0]  raddr_i,
  output logic [ADDR_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o
);
  localparam int unsigned N_LIM = 2;
  localparam logic [SPR_W-1:0] NUMS [N_LIM] = '{LO_NUM, HI_NUM};

  logic [ADDR_W-1:0] lim_q [N_LIM];

  for (genvar g = 0; g < N_LIM; g++) begin : g_lim
    // lower bound resets open at 0, upper bound open at all ones
    localparam logic [ADDR_W-1:0] RST_VAL = (g == 1) ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              lim_q[g] <= RST_VAL;
      else if (wr_i && (waddr_i == NUMS[g]))    lim_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_LIM; i++)
      if (raddr_i == NUMS[i]) rdata_o = lim_q[i];
  end

  assign lo_o = lim_q[0];
  assign hi_o = lim_q[1];
endmodule

// File: rtl/sw_qualify.sv
module sw_qualify #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned SP_IDX = 1
) (
  input  logic             valid_i,
  input  logic             reg_reg_i,
  input  logic [IDX_W-1:0] ra_i,
  input  logic [IDX_W-1:0] rb_i,
  output logic             check_o
);
  localparam logic [IDX_W-1:0] SP = IDX_W'(SP_IDX);

  logic ra_sp, rb_sp;
  assign ra_sp = (ra_i == SP);
  // index register only counts in register+register form
  assign rb_sp = reg_reg_i && (rb_i == SP);
  assign check_o = valid_i && (ra_sp || rb_sp);
endmodule

// File: rtl/sw_compare.sv
module sw_compare #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic              viol_o
);
  logic below, above;
  assign below  = addr_i < lo_i;
  assign above  = addr_i > hi_i;
  assign viol_o = en_i && (below || above);
endmodule

// File: rtl/sw_syndrome.sv
module sw_syndrome #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] CAUSE = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fault_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [ADDR_W-1:0]  ear_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ear_o   <= '0;
      cause_o <= '0;
    end else if (fault_i) begin
      ear_o   <= addr_i;
      cause_o <= CAUSE;
    end
  end
endmodule

// File: rtl/stack_window_guard.sv
module stack_window_guard
  import sw_guard_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned IW  = IDX_W,
  parameter int unsigned SW  = SPR_W,
  parameter int unsigned CW  = CAUSE_W,
  parameter int unsigned SPI = SP_IDX,
  parameter logic [SW-1:0] LO_SPR = LO_NUM,
  parameter logic [SW-1:0] HI_SPR = HI_NUM,
  parameter logic [CW-1:0] CAUSE_CODE = CAUSE_STACK
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          spr_wr_i,
  input  logic [SW-1:0] spr_waddr_i,
  input  logic [AW-1:0] spr_wdata_i,
  input  logic [SW-1:0] spr_raddr_i,
  output logic [AW-1:0] spr_rdata_o,
  input  logic          ls_valid_i,
  input  logic          ls_reg_reg_i,
  input  logic [IW-1:0] ls_ra_i,
  input  logic [IW-1:0] ls_rb_i,
  input  logic [AW-1:0] ls_addr_i,
  output logic          fault_o,
  output logic [AW-1:0] ear_o,
  output logic [CW-1:0] cause_o
);
  logic [AW-1:0] lim_lo, lim_hi;
  logic          do_check;

  sw_limit_regs #(.ADDR_W(AW), .SPR_W(SW), .LO_NUM(LO_SPR), .HI_NUM(HI_SPR)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (spr_wr_i),
    .waddr_i (spr_waddr_i),
    .wdata_i (spr_wdata_i),
    .raddr_i (spr_raddr_i),
    .rdata_o (spr_rdata_o),
    .lo_o    (lim_lo),
    .hi_o    (lim_hi)
  );

  sw_qualify #(.IDX_W(IW), .SP_IDX(SPI)) u_qual (
    .valid_i   (ls_valid_i),
    .reg_reg_i (ls_reg_reg_i),
    .ra_i      (ls_ra_i),
    .rb_i      (ls_rb_i),
    .check_o   (do_check)
  );

  // compares against registered bounds, so a same-cycle write is not yet seen
  sw_compare #(.ADDR_W(AW)) u_cmp (
    .en_i   (do_check),
    .addr_i (ls_addr_i),
    .lo_i   (lim_lo),
    .hi_i   (lim_hi),
    .viol_o (fault_o)
  );

  sw_syndrome #(.ADDR_W(AW), .CAUSE_W(CW), .CAUSE(CAUSE_CODE)) u_syn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (fault_o),
    .addr_i  (ls_addr_i),
    .ear_o   (ear_o),
    .cause_o (cause_o)
  );
endmodule

// File: rtl/sw_guard_checker.sv
module sw_guard_checker #(
  parameter int unsigned AW  = 32,
  parameter int unsigned IW  = 5,
  parameter int unsigned SW  = 14,
  parameter int unsigned CW  = 5,
  parameter int unsigned SPI = 1,
  parameter logic [SW-1:0] LO_SPR = '0,
  parameter logic [SW-1:0] HI_SPR = '0,
  parameter logic [CW-1:0] CAUSE_CODE = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          spr_wr_i,
  input logic [SW-1:0] spr_waddr_i,
  input logic          ls_valid_i,
  input logic          ls_reg_reg_i,
  input logic [IW-1:0] ls_ra_i,
  input logic [IW-1:0] ls_rb_i,
  input logic [AW-1:0] ls_addr_i,
  input logic          fault_o,
  input logic [AW-1:0] ear_o,
  input logic [CW-1:0] cause_o,
  input logic [AW-1:0] lim_lo,
  input logic [AW-1:0] lim_hi
);
  localparam logic [IW-1:0] SP = IW'(SPI);

  AST_FAULT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ls_valid_i);  // R7

  AST_FAULT_NEEDS_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (ls_ra_i == SP || (ls_reg_reg_i && ls_rb_i == SP)));  // R5 R6

  AST_FAULT_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (ls_addr_i < lim_lo || ls_addr_i > lim_hi));  // R4

  AST_EAR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> ear_o == $past(ls_addr_i));  // R8

  AST_CAUSE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> cause_o == CAUSE_CODE);  // R8

  AST_SYNDROME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |=> ($stable(ear_o) && $stable(cause_o)));  // R8

  AST_BOUNDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spr_wr_i || (spr_waddr_i != LO_SPR && spr_waddr_i != HI_SPR))
      |=> ($stable(lim_lo) && $stable(lim_hi)));  // R3
endmodule

bind stack_window_guard sw_guard_checker #(
  .AW(AW), .IW(IW), .SW(SW), .CW(CW), .SPI(SPI),
  .LO_SPR(LO_SPR), .HI_SPR(HI_SPR), .CAUSE_CODE(CAUSE_CODE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .spr_wr_i     (spr_wr_i),
  .spr_waddr_i  (spr_waddr_i),
  .ls_valid_i   (ls_valid_i),
  .ls_reg_reg_i (ls_reg_reg_i),
  .ls_ra_i      (ls_ra_i),
  .ls_rb_i      (ls_rb_i),
  .ls_addr_i    (ls_addr_i),
  .fault_o      (fault_o),
  .ear_o        (ear_o),
  .cause_o      (cause_o),
  .lim_lo       (lim_lo),
  .lim_hi       (lim_hi)
);

// File: tb/stack_window_guard_tb_top.sv
module stack_window_guard_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        spr_wr_i = 1'b0;
  logic [13:0] spr_waddr_i = '0;
  logic [31:0] spr_wdata_i = '0;
  logic [13:0] spr_raddr_i = '0;
  logic [31:0] spr_rdata_o;
  logic        ls_valid_i = 1'b0;
  logic        ls_reg_reg_i = 1'b0;
  logic [4:0]  ls_ra_i = '0;
  logic [4:0]  ls_rb_i = '0;
  logic [31:0] ls_addr_i = '0;
  logic        fault_o;
  logic [31:0] ear_o;
  logic [4:0]  cause_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] lo_m, hi_m, ear_m;
  logic [4:0]  cause_m;

  always #4 clk_i = ~clk_i;

  stack_window_guard dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spr_write(input logic [13:0] num, input logic [31:0] val);
    @(negedge clk_i);
    spr_wr_i = 1'b1; spr_waddr_i = num; spr_wdata_i = val;
    @(negedge clk_i);
    spr_wr_i = 1'b0;
    if (num == 14'h800) lo_m = val;
    if (num == 14'h802) hi_m = val;
  endtask

  task automatic read_bounds(input string req);
    spr_raddr_i = 14'h800; #1; chk(req, spr_rdata_o, lo_m);
    spr_raddr_i = 14'h802; #1; chk(req, spr_rdata_o, hi_m);
  endtask

  // one access, sampled mid-cycle; syndrome sampled after the next edge
  task automatic access(input string req, input logic v, input logic rr,
                        input logic [4:0] ra, input logic [4:0] rb, input logic [31:0] a);
    logic qual, exp_f;
    @(negedge clk_i);
    ls_valid_i = v; ls_reg_reg_i = rr; ls_ra_i = ra; ls_rb_i = rb; ls_addr_i = a;
    qual  = v && (ra == 5'd1 || (rr && rb == 5'd1));
    exp_f = qual && (a < lo_m || a > hi_m);
    #1;
    chk(req, {31'd0, fault_o}, {31'd0, exp_f});
    if (exp_f) begin ear_m = a; cause_m = 5'd7; end
    @(negedge clk_i);
    ls_valid_i = 1'b0;
    #1;
    chk("R8", ear_o, ear_m);
    chk("R8", {27'd0, cause_o}, {27'd0, cause_m});
  endtask

  initial begin
    logic [31:0] addrs [7];
    addrs = '{32'h0000_0FFF, 32'h0000_1000, 32'h0000_1800, 32'h0000_1FFF,
              32'h0000_2000, 32'h0000_0000, 32'hFFFF_FFFF};
    lo_m = '0; hi_m = '1; ear_m = '0; cause_m = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    read_bounds("R1");
    chk("R1", ear_o, 32'h0);
    chk("R1", {27'd0, cause_o}, 32'h0);
    access("R1", 1'b1, 1'b0, 5'd1, 5'd0, 32'h0);
    access("R1", 1'b1, 1'b1, 5'd1, 5'd1, 32'hFFFF_FFFF);
    // R2 program the window
    spr_write(14'h800, 32'h0000_1000);
    spr_write(14'h802, 32'h0000_1FFF);
    read_bounds("R2");
    // R3 unmapped numbers
    spr_write(14'h801, 32'hDEAD_BEEF);
    spr_write(14'h803, 32'h1234_5678);
    spr_write(14'h000, 32'hFFFF_0000);
    spr_write(14'h1800, 32'h0);
    read_bounds("R3");
    spr_raddr_i = 14'h801; #1; chk("R3", spr_rdata_o, 32'h0);
    // R4 R5 R6 sweep
    for (int rr = 0; rr < 2; rr++)
      for (int ra = 0; ra < 4; ra++)
        for (int rb = 0; rb < 4; rb++)
          for (int k = 0; k < 7; k++)
            access(rr ? "R5/R4" : "R6/R4", 1'b1, rr[0], 5'(ra), 5'(rb), addrs[k]);
    access("R6", 1'b1, 1'b0, 5'd31, 5'd1, 32'h0);
    access("R5", 1'b1, 1'b1, 5'd31, 5'd1, 32'h0);
    // R7 no strobe, no fault
    access("R7", 1'b0, 1'b1, 5'd1, 5'd1, 32'h0);
    access("R7", 1'b0, 1'b0, 5'd1, 5'd0, 32'hFFFF_FFFF);
    // R9 write and access in the same cycle
    @(negedge clk_i);
    spr_wr_i = 1'b1; spr_waddr_i = 14'h800; spr_wdata_i = 32'h0000_1800;
    ls_valid_i = 1'b1; ls_reg_reg_i = 1'b0; ls_ra_i = 5'd1; ls_addr_i = 32'h0000_1400;
    #1; chk("R9", {31'd0, fault_o}, 32'd0);
    @(negedge clk_i);
    spr_wr_i = 1'b0; ls_valid_i = 1'b0;
    lo_m = 32'h0000_1800;
    access("R9", 1'b1, 1'b0, 5'd1, 5'd0, 32'h0000_1400);
    access("R9", 1'b1, 1'b0, 5'd1, 5'd0, 32'h0000_1800);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule